// File: doc/BRIEF.md
# Three-Wire Camera Control Bus Master

This block issues register accesses to camera sensors over a three-wire control bus: an active-low enable line, a bit clock driven only by the master, and one data line that either side may drive. The data line is split into `sda_o`, `sda_oe` and `sda_i` so that the pad can be placed outside the block. A host presents a request with a 7-bit slave ID, a sub-address, a write byte and a 2-bit command. The block then builds the bus frame from phases of nine bits each. Every phase carries one byte, most significant bit first, followed by a ninth bit that the master does not check.

A register read is done in two steps. The first is a two-phase write that sets the sub-address. The second is a separate two-phase read, and the enable line returns high between the two. In the read, the master releases the data line for the slave's eight data bits and then drives the ninth bit high. A level input `sleep_req` puts the bus into a low-power state. In that state the power-down output is asserted and all three bus lines are driven low, with a programmed margin around the power-down edges. Every interval is a parameter counted in system clock cycles: the bit half-period, the precharge time, the pre-active time, the data-change margin and the suspend margin.

Top module: `cam3w_master`

## Requirements
- R1: After reset and between transactions, `bus_en_n`=1, `bus_clk`=1, `sda_oe`=0, `pwr_dn_n`=1 and `busy`=0.
- R2: The data line is driven to 1 for exactly PRE_CYC cycles before `bus_en_n` falls. It is driven to 1 for exactly PRE_CYC cycles after `bus_en_n` rises, and is then released.
- R3: `bus_en_n` stays low for the whole transaction. The first fall of `bus_clk` comes PRA_CYC cycles after `bus_en_n` falls. Each clock low half and each clock high half lasts HALF_CYC cycles.
- R4: A transaction has 9 clock pulses per phase. Command 2'b00 sends three phases (ID, sub-address, write byte), which is 27 pulses. Commands 2'b01, 2'b10 and 2'b11 send two phases, which is 18 pulses. The first phase byte is {id[6:0], rw}, where rw=1 only for command 2'b10. The second byte is the sub-address, except in a read. Bytes go out MSB first.
- R5: While `bus_en_n` is low, `sda_o` and `sda_oe` never change while `bus_clk` is high. Any change happens exactly MRG_CYC cycles after `bus_clk` falls.
- R6: On the ninth bit of every phase the master sends, `sda_oe` is 0 while the clock is high. Whatever the slave drives on such a bit has no effect on the pulse count, on the bytes that follow, or on `rdata`.
- R7: In a read (command 2'b10), the master releases the line (`sda_oe`=0) for the eight data bits of phase two. It samples `sda_i` at the end of each clock high half and shifts the bits into `rdata`, MSB first. It then drives the ninth bit to 1.
- R8: A request is accepted only when `req_valid`=1, `busy`=0 and `sleep_req`=0. `busy` stays high until the transaction ends, and a request raised while busy starts no transaction. `done` is a single-cycle pulse in the first idle cycle after the transaction.
- R9: When `sleep_req` is high in idle (it wins over a request in the same cycle), `pwr_dn_n` falls first. SUS_CYC cycles later the enable, clock and data lines are all driven low (`sda_oe`=1). No request is accepted during suspend. When `sleep_req` drops, the lines return to their idle levels, and SUS_CYC cycles later `pwr_dn_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 2 | 00 three-phase write, 01 two-phase write, 10 two-phase read, 11 as 01 |
| req_id | input | 7 | Slave ID |
| req_sub | input | 8 | Sub-address |
| req_wdata | input | 8 | Write byte |
| sleep_req | input | 1 | Level request for suspend |
| busy | output | 1 | Transaction or suspend in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 8 | Last byte read from the bus |
| bus_en_n | output | 1 | Active-low bus enable |
| bus_clk | output | 1 | Bit clock |
| sda_o | output | 1 | Data line drive value |
| sda_oe | output | 1 | Data line drive enable |
| sda_i | input | 1 | Data line sampled value |
| pwr_dn_n | output | 1 | Active-low power-down |

## Verification
The hardest case to reach from the ports is the ninth bit. There the master lets go of the line and a slave may be driving anything, yet the bytes before and after must stay correct and the read byte must stay untouched. The bench's slave model drives random levels on every bit the master has released, except the read data bits, which carry a chosen byte. Together with a request raised mid-transaction and a sleep request raised in the same cycle as a transfer request, this reaches the release, refusal and priority paths. Random IDs, sub-addresses and data then cover many bit patterns.

// File: rtl/cam3w_pkg.sv
package cam3w_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_LOW, ST_HIGH, ST_POST, ST_SIN, ST_SUS, ST_SOUT
  } seq_st_e;

  localparam logic [1:0] CMD_WR3 = 2'b00;
  localparam logic [1:0] CMD_RD2 = 2'b10;
  localparam int unsigned BITS_PER_PHASE = 9;

  function automatic logic [1:0] phase_total(input logic [1:0] cmd);
    return (cmd == CMD_WR3) ? 2'd3 : 2'd2;
  endfunction

  function automatic logic is_read(input logic [1:0] cmd);
    return cmd == CMD_RD2;
  endfunction

  function automatic logic [7:0] phase_byte(input logic [1:0] cmd, input logic [1:0] ph,
                                            input logic [6:0] id, input logic [7:0] sub,
                                            input logic [7:0] wd);
    case (ph)
      2'd0:    return {id, is_read(cmd)};
      2'd1:    return sub;
      default: return wd;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, b, c, d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned state_span(input seq_st_e st, input int unsigned half,
                                             input int unsigned pre, input int unsigned pra,
                                             input int unsigned sus);
    case (st)
      ST_PRE, ST_POST: return pre;
      ST_ACT:          return pra;
      ST_LOW, ST_HIGH: return half;
      ST_SIN, ST_SOUT: return sus;
      default:         return 1;
    endcase
  endfunction

endpackage

// File: rtl/cam3w_timer.sv
module cam3w_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cam3w_framer.sv
module cam3w_framer
  import cam3w_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv,
  input  logic [1:0] cmd,
  input  logic [6:0] id,
  input  logic [7:0] sub,
  input  logic [7:0] wd,
  output logic       drv_oe,
  output logic       drv_val,
  output logic       ninth,
  output logic       rx_phase,
  output logic       slave_bit,
  output logic       last_bit
);
  logic [1:0] ph;
  logic [3:0] bn;
  logic [7:0] cur_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
      bn <= '0;
    end else if (clr) begin
      ph <= '0;
      bn <= '0;
    end else if (adv) begin
      if (bn == 4'(BITS_PER_PHASE - 1)) begin
        bn <= '0;
        ph <= ph + 2'd1;
      end else begin
        bn <= bn + 4'd1;
      end
    end
  end

  assign cur_byte  = phase_byte(cmd, ph, id, sub, wd);
  assign ninth     = (bn == 4'(BITS_PER_PHASE - 1));
  assign rx_phase  = is_read(cmd) && (ph == 2'd1);
  assign slave_bit = rx_phase && !ninth;
  assign last_bit  = ninth && (ph == phase_total(cmd) - 2'd1);
  // master bits driven; slave bits released; ninth: released unless NA bit of a read
  assign drv_oe    = ninth ? rx_phase : !rx_phase;
  assign drv_val   = ninth ? 1'b1 : cur_byte[3'd7 - bn[2:0]];

  AST_BIT_WITHIN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ninth) |=> !$stable(bn)) else $error("bit index stalled"); // R4
endmodule

// File: rtl/cam3w_seq.sv
module cam3w_seq
  import cam3w_pkg::*;
#(
  parameter int unsigned HALF_CYC = 8,
  parameter int unsigned PRE_CYC  = 2,
  parameter int unsigned PRA_CYC  = 4,
  parameter int unsigned MRG_CYC  = 2,
  parameter int unsigned SUS_CYC  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sleep,
  input  logic last_bit,
  output logic load_stb,
  output logic smp_stb,
  output logic fin,
  output logic busy,
  output logic bus_en_n,
  output logic bus_clk,
  output logic pwr_dn_n,
  output logic use_bit,
  output logic line_oe,
  output logic line_val
);
  localparam int unsigned SPAN_MAX = max4(HALF_CYC, PRE_CYC, PRA_CYC, SUS_CYC);
  localparam int CW = $clog2(SPAN_MAX + 1);

  seq_st_e st, nxt;
  logic [CW-1:0] cnt;
  logic          st_chg;
  logic          end_now;
  int unsigned   span_now;

  cam3w_timer #(.W(CW)) u_tmr (.clk(clk), .rst_n(rst_n), .clr(st_chg), .cnt(cnt));

  assign st_chg   = (nxt != st);
  assign span_now = state_span(st, HALF_CYC, PRE_CYC, PRA_CYC, SUS_CYC);
  assign end_now  = (32'(cnt) + 32'd1 == span_now);

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE: if (sleep) nxt = ST_SIN; else if (start) nxt = ST_PRE;
      ST_PRE:  if (end_now) nxt = ST_ACT;
      ST_ACT:  if (end_now) nxt = ST_LOW;
      ST_LOW:  if (end_now) nxt = ST_HIGH;
      ST_HIGH: if (end_now) nxt = last_bit ? ST_POST : ST_LOW;
      ST_POST: if (end_now) nxt = ST_IDLE;
      ST_SIN:  if (end_now) nxt = ST_SUS;
      ST_SUS:  if (!sleep)  nxt = ST_SOUT;
      ST_SOUT: if (end_now) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign load_stb = (st == ST_LOW) && (32'(cnt) + 32'd1 == MRG_CYC);
  assign smp_stb  = (st == ST_HIGH) && end_now;
  assign fin      = (st == ST_POST) && end_now;
  assign busy     = (st != ST_IDLE);
  assign bus_en_n = !(st inside {ST_ACT, ST_LOW, ST_HIGH, ST_SUS});
  assign bus_clk  = !(st inside {ST_LOW, ST_SUS});
  assign pwr_dn_n = !(st inside {ST_SIN, ST_SUS, ST_SOUT});
  assign use_bit  = (st inside {ST_LOW, ST_HIGH});
  assign line_oe  = (st inside {ST_PRE, ST_ACT, ST_POST, ST_SUS});
  assign line_val = (st != ST_SUS);

  AST_PWR_FALL_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_dn_n) |-> (bus_en_n && bus_clk)) else $error("lines moved with power-down"); // R9
  AST_PWR_RISE_AFTER_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_dn_n) |-> ($past(bus_en_n) && $past(bus_clk))) else $error("power-up before lines"); // R9
endmodule

// File: rtl/cam3w_master.sv
module cam3w_master
  import cam3w_pkg::*;
#(
  parameter int unsigned HALF_CYC = 8,
  parameter int unsigned PRE_CYC  = 2,
  parameter int unsigned PRA_CYC  = 4,
  parameter int unsigned MRG_CYC  = 2,
  parameter int unsigned SUS_CYC  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_cmd,
  input  logic [6:0] req_id,
  input  logic [7:0] req_sub,
  input  logic [7:0] req_wdata,
  input  logic       sleep_req,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       bus_en_n,
  output logic       bus_clk,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic       sda_i,
  output logic       pwr_dn_n
);
  logic       accept;
  logic [1:0] cmd_q;
  logic [6:0] id_q;
  logic [7:0] sub_q, wd_q, rsh;
  logic       sda_q, oe_q;
  logic       load_stb, smp_stb, fin, use_bit, line_oe, line_val;
  logic       drv_oe, drv_val, ninth, rx_phase, slave_bit, last_bit;
  logic       din_masked;

  assign accept = req_valid && !busy && !sleep_req;

  cam3w_seq #(
    .HALF_CYC(HALF_CYC), .PRE_CYC(PRE_CYC), .PRA_CYC(PRA_CYC),
    .MRG_CYC(MRG_CYC), .SUS_CYC(SUS_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .sleep(sleep_req), .last_bit(last_bit),
    .load_stb(load_stb), .smp_stb(smp_stb), .fin(fin), .busy(busy),
    .bus_en_n(bus_en_n), .bus_clk(bus_clk), .pwr_dn_n(pwr_dn_n),
    .use_bit(use_bit), .line_oe(line_oe), .line_val(line_val)
  );

  cam3w_framer u_frm (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(smp_stb),
    .cmd(cmd_q), .id(id_q), .sub(sub_q), .wd(wd_q),
    .drv_oe(drv_oe), .drv_val(drv_val), .ninth(ninth), .rx_phase(rx_phase),
    .slave_bit(slave_bit), .last_bit(last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      id_q  <= '0;
      sub_q <= '0;
      wd_q  <= '0;
      sda_q <= 1'b1;
      oe_q  <= 1'b1;
    end else if (accept) begin
      cmd_q <= req_cmd;
      id_q  <= req_id;
      sub_q <= req_sub;
      wd_q  <= req_wdata;
      sda_q <= 1'b1;
      oe_q  <= 1'b1;
    end else if (load_stb) begin
      sda_q <= drv_val;
      oe_q  <= drv_oe;
    end
  end

  // input is forced to 0 outside a transaction and on every ninth bit
  assign din_masked = !bus_en_n && !ninth && sda_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsh  <= '0;
      done <= 1'b0;
    end else begin
      done <= fin;
      if (smp_stb && slave_bit) rsh <= {rsh[6:0], din_masked};
    end
  end

  assign rdata  = rsh;
  assign sda_oe = use_bit ? oe_q  : line_oe;
  assign sda_o  = use_bit ? sda_q : line_val;

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_en_n && bus_clk && !sda_oe && pwr_dn_n)) else $error("idle levels"); // R1
  AST_EN_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_en_n) && pwr_dn_n) |-> ($past(sda_oe) && $past(sda_o))) else $error("no precharge"); // R2
  AST_DATA_STILL_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_clk && $past(bus_clk) && !bus_en_n && $past(!bus_en_n)) |-> ($stable(sda_o) && $stable(sda_oe)))
    else $error("data moved while clock high"); // R5
  AST_NINTH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_clk && !bus_en_n && ninth && !rx_phase && use_bit) |-> !sda_oe) else $error("ninth bit driven"); // R6
  AST_NA_DRIVEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_clk && !bus_en_n && ninth && rx_phase && use_bit) |-> (sda_oe && sda_o)) else $error("NA bit"); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))) else $error("done outside end"); // R8
endmodule

// File: tb/tb_cam3w_master.sv
`timescale 1ns/1ps
module tb_cam3w_master;
  localparam int HALF = 8, PRE = 2, PRA = 4, MRG = 2, SUS = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, sleep_req = 0;
  logic [1:0] req_cmd = 0;
  logic [6:0] req_id = 0;
  logic [7:0] req_sub = 0, req_wdata = 0;
  logic busy, done, bus_en_n, bus_clk, sda_o, sda_oe, sda_i, pwr_dn_n;
  logic [7:0] rdata;
  logic slv = 0;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  assign sda_i = sda_oe ? sda_o : slv;

  cam3w_master #(.HALF_CYC(HALF), .PRE_CYC(PRE), .PRA_CYC(PRA), .MRG_CYC(MRG), .SUS_CYC(SUS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd), .req_id(req_id),
    .req_sub(req_sub), .req_wdata(req_wdata), .sleep_req(sleep_req), .busy(busy), .done(done),
    .rdata(rdata), .bus_en_n(bus_en_n), .bus_clk(bus_clk), .sda_o(sda_o), .sda_oe(sda_oe),
    .sda_i(sda_i), .pwr_dn_n(pwr_dn_n));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_pulses(input logic [1:0] c);
    return (c == 2'b00) ? 27 : 18;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [1:0] c, input int ph, input logic [6:0] i,
                                          input logic [7:0] s, input logic [7:0] w);
    if (ph == 0) return {i, (c == 2'b10) ? 1'b1 : 1'b0};
    if (ph == 1) return s;
    return w;
  endfunction

  // bus monitor
  int cyc = 0, run = 0, pre_len = 0, post_len = 0, pra_len = 0, t_en = 0, t_fall = 0;
  int half_bad = 0, chg_bad = 0, stab_bad = 0, nbits = 0, starts = 0, dones = 0;
  logic first_fall = 0, mon_rd = 0;
  logic [7:0] rd_byte = 0;
  logic cap_oe [0:31];
  logic cap_v [0:31];
  logic p_en = 1, p_clk = 1, p_oe = 0, p_sd = 0, p_pw = 1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (done) dones++;
      if (pwr_dn_n && p_pw) begin
        if (!bus_en_n && p_en) begin
          starts++; pre_len = run; t_en = cyc; first_fall = 1;
          nbits = 0; half_bad = 0; chg_bad = 0; stab_bad = 0; post_len = 0;
        end
        if (!bus_en_n && !p_en) begin
          if (!bus_clk && p_clk) begin
            if (first_fall) begin pra_len = cyc - t_en; first_fall = 0; end
            else if (cyc - t_fall != 2 * HALF) half_bad++;
            t_fall = cyc;
            slv = (mon_rd && nbits >= 9 && nbits <= 16) ? rd_byte[16 - nbits] : 1'($urandom % 2);
          end
          if (bus_clk && !p_clk) begin
            if (cyc - t_fall != HALF) half_bad++;
            if (nbits < 32) begin cap_oe[nbits] = sda_oe; cap_v[nbits] = sda_o; end
            nbits++;
          end
          if (bus_clk && p_clk && (sda_o != p_sd || sda_oe != p_oe)) stab_bad++;
          if (!bus_clk && (sda_o != p_sd || sda_oe != p_oe) && cyc - t_fall != MRG) chg_bad++;
        end
        if (bus_en_n && oe_drv1()) run++;
        else begin
          if (run != 0 && bus_en_n) post_len = run;
          run = 0;
        end
      end
    end
    p_en = bus_en_n; p_clk = bus_clk; p_oe = sda_oe; p_sd = sda_o; p_pw = pwr_dn_n;
  end

  function automatic logic oe_drv1();
    return sda_oe && sda_o;
  endfunction

  task automatic xfer(input logic [1:0] c, input logic [6:0] i, input logic [7:0] s,
                      input logic [7:0] w, input logic [7:0] r);
    int k, st0, dn0, bad_m, bad_n, bad_r;
    while (busy) @(negedge clk);
    rd_byte = r; mon_rd = (c == 2'b10);
    st0 = starts; dn0 = dones;
    req_cmd = c; req_id = i; req_sub = s; req_wdata = w; req_valid = 1;
    @(negedge clk); req_valid = 0;
    repeat (5) @(negedge clk);
    req_cmd = 2'b00; req_valid = 1;            // must be refused while busy (R8)
    @(negedge clk); req_valid = 0;
    k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    repeat (40) @(negedge clk);
    check(starts - st0 == 1, "R8 one start per request", starts - st0, 1);
    check(dones - dn0 == 1 && !busy, "R8 single done pulse", dones - dn0, 1);
    check(nbits == exp_pulses(c), "R4 pulse count", nbits, exp_pulses(c));
    bad_m = 0; bad_n = 0; bad_r = 0;
    for (int p = 0; p < exp_pulses(c) && p < 32; p++) begin
      int ph, b; logic [7:0] eb;
      ph = p / 9; b = p % 9; eb = exp_byte(c, ph, i, s, w);
      if (c == 2'b10 && ph == 1) begin
        if (b < 8 && cap_oe[p] !== 1'b0) bad_r++;
        if (b == 8 && (cap_oe[p] !== 1'b1 || cap_v[p] !== 1'b1)) bad_r++;
      end else if (b == 8) begin
        if (cap_oe[p] !== 1'b0) bad_n++;
      end else if (cap_oe[p] !== 1'b1 || cap_v[p] !== eb[7 - b]) bad_m++;
    end
    check(bad_m == 0, "R4 master bits MSB first", bad_m, 0);
    check(bad_n == 0, "R6 ninth bit released", bad_n, 0);
    check(pre_len == PRE && post_len == PRE, "R2 precharge", pre_len * 256 + post_len, PRE * 256 + PRE);
    check(pra_len == PRA && half_bad == 0, "R3 pre-active and halves", pra_len * 256 + half_bad, PRA * 256);
    check(stab_bad == 0 && chg_bad == 0, "R5 data changes on low clock", stab_bad * 256 + chg_bad, 0);
    if (c == 2'b10) begin
      check(bad_r == 0, "R7 read release and NA", bad_r, 0);
      check(rdata == r, "R7 read data", rdata, r);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t0;
    logic [7:0] keep;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(bus_en_n && bus_clk && !sda_oe && pwr_dn_n && !busy && !done, "R1 reset state",
          {bus_en_n, bus_clk, sda_oe, pwr_dn_n, busy, done}, 6'b110100);

    xfer(2'b00, 7'h21, 8'h0F, 8'hA5, 8'h00);
    xfer(2'b01, 7'h42, 8'h80, 8'h00, 8'h00);
    xfer(2'b10, 7'h42, 8'h00, 8'h00, 8'h00);
    xfer(2'b10, 7'h7F, 8'h00, 8'h00, 8'hFF);
    xfer(2'b10, 7'h01, 8'h00, 8'h00, 8'h96);
    keep = rdata;
    xfer(2'b11, 7'h55, 8'h3C, 8'hFF, 8'h00);
    check(rdata == keep, "R6 write ninth bits leave rdata", rdata, keep);
    check(bus_en_n && bus_clk && !sda_oe && pwr_dn_n, "R1 idle between transactions",
          {bus_en_n, bus_clk, sda_oe, pwr_dn_n}, 4'b1101);

    for (int n = 0; n < 12; n++)
      xfer(2'($urandom % 4), 7'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));

    // suspend, with a simultaneous request that must lose (R9)
    while (busy) @(negedge clk);
    t0 = starts;
    sleep_req = 1; req_valid = 1; req_cmd = 2'b00;
    @(negedge clk); req_valid = 0;
    check(!pwr_dn_n && bus_en_n && bus_clk, "R9 power-down leads lines",
          {pwr_dn_n, bus_en_n, bus_clk}, 3'b011);
    repeat (SUS - 1) @(negedge clk);
    check(bus_en_n && bus_clk, "R9 lines held before margin", {bus_en_n, bus_clk}, 2'b11);
    @(negedge clk);
    check(!bus_en_n && !bus_clk && sda_oe && !sda_o && busy, "R9 suspend lines low",
          {bus_en_n, bus_clk, sda_oe, sda_o, busy}, 5'b00101);
    req_valid = 1; @(negedge clk); req_valid = 0;
    repeat (20) @(negedge clk);
    check(!bus_en_n && !bus_clk && starts == t0, "R9 request refused in suspend", starts - t0, 0);
    sleep_req = 0;
    @(negedge clk);
    check(bus_en_n && bus_clk && !sda_oe && !pwr_dn_n, "R9 lines restored first",
          {bus_en_n, bus_clk, sda_oe, pwr_dn_n}, 4'b1100);
    repeat (SUS - 1) @(negedge clk);
    check(!pwr_dn_n, "R9 power-down held for margin", pwr_dn_n, 0);
    @(negedge clk);
    check(pwr_dn_n && !busy, "R9 power-down released", {pwr_dn_n, busy}, 2'b10);

    xfer(2'b10, 7'h33, 8'h00, 8'h00, 8'h5A);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule